// File: doc/BRIEF.md
# Timer Output-Compare Channel Stage

This block is one output channel of a general-purpose timer. Each clock it takes the count value and the counting direction from a counter outside the block. It compares the count with a programmable channel value and updates a registered reference waveform, following a 3-bit mode field. The modes are frozen, set on match, clear on match, toggle on match, force low, force high, and two mirrored PWM shapes. The reference then passes through a polarity selector and an enable gate to reach the pin. A compare flag reports every cycle in which the counter equalled the channel value.

In PWM use, the counter's period sets the waveform period and the channel value sets the duty cycle. In PWM mode the shape also depends on the counting direction, so up, down and centre-aligned counters give the expected edges. Software, or a parent block, writes two registers through a simple parallel port: a control word and the compare value.

Top module: `tmr_oc_channel`

## Requirements
- R1: After reset, the control word and the compare value are 0, and `oc_ref`, `pin_out` and `cmp_flag` are all 0.
- R2: A write with `cfg_we`=1 loads the control word when `cfg_addr`=0 and the compare value when `cfg_addr`=1, on that clock edge. The control word fields are [1:0] channel select, [4:2] mode, [5] polarity invert and [6] output enable. A new control word governs `oc_ref` from the next clock edge onward.
- R3: When the channel select is 2'b00, `oc_ref` becomes 0 on the next edge, whatever the mode.
- R4: Mode 3'b000 (frozen) keeps `oc_ref` at its current value.
- R5: Mode 3'b001 sets `oc_ref` to 1 on an edge where count equals the compare value. Mode 3'b010 clears it to 0 on such an edge. On any other edge, both modes hold `oc_ref`.
- R6: Mode 3'b011 inverts `oc_ref` on each edge where count equals the compare value and holds it otherwise.
- R7: Mode 3'b100 drives `oc_ref` to 0 and mode 3'b101 drives it to 1, regardless of the count.
- R8: Mode 3'b110 (PWM A): when counting up (`cnt_down`=0), `oc_ref` becomes 1 if compare > count and 0 otherwise. When counting down, it becomes 1 if compare >= count and 0 otherwise.
- R9: Mode 3'b111 (PWM B) gives the inverse of PWM A in both directions.
- R10: `pin_out` equals `oc_ref` XOR polarity-invert while output enable is 1, and is 0 while output enable is 0.
- R11: `cmp_flag` is 1 in the cycle after an edge where count equals the compare value, and 0 after any other edge. This holds in every mode, the forced modes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: control word, 1: compare value |
| cfg_wdata | input | CNT_W | Configuration write data |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| oc_ref | output | 1 | Registered reference waveform |
| pin_out | output | 1 | Polarity-adjusted, enabled channel output |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
The state that matters is the one-bit reference register. A wrong next-state choice shows on `oc_ref` and `pin_out` one edge after the offending count value. It then persists in the hold-type modes until the next match or forced write. The bench therefore sweeps full count ranges in both directions with the compare value in the middle. This exposes off-by-one errors at the equality boundary, where PWM A differs between up and down counting. Flag errors appear one cycle after the matching count, and the forced modes are included in that check.

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  output logic             oc_ref,
  output logic             pin_out,
  output logic             cmp_flag
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              ref_d;

  wire [1:0] chan_sel = ctrl_q[1:0];
  wire [2:0] mode     = ctrl_q[4:2];
  wire       pol_inv  = ctrl_q[5];
  wire       out_en   = ctrl_q[6];

  wire match  = (cnt_val == cmp_q);
  wire pwm_a  = cnt_down ? (cmp_q >= cnt_val) : (cmp_q > cnt_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) cmp_q  <= cfg_wdata;
      else          ctrl_q <= cfg_wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    ref_d = oc_ref;
    if (chan_sel == 2'b00) ref_d = 1'b0;
    else begin
      case (mode)
        3'b001:  if (match) ref_d = 1'b1;
        3'b010:  if (match) ref_d = 1'b0;
        3'b011:  if (match) ref_d = ~oc_ref;
        3'b100:  ref_d = 1'b0;
        3'b101:  ref_d = 1'b1;
        3'b110:  ref_d = pwm_a;
        3'b111:  ref_d = ~pwm_a;
        default: ref_d = oc_ref;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_ref   <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      oc_ref   <= ref_d;
      cmp_flag <= match;
    end
  end

  assign pin_out = out_en & (oc_ref ^ pol_inv);
endmodule

module tmr_oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_down,
  input logic [CNT_W-1:0] cmp_q,
  input logic [6:0]       ctrl_q,
  input logic             oc_ref,
  input logic             cmp_flag
);
  wire on = ctrl_q[1:0] != 2'b00;
  wire [2:0] md = ctrl_q[4:2];
  wire hit = cnt_val == cmp_q;

  assert_sel_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !oc_ref);
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    on && md == 3'b000 |=> $stable(oc_ref));
  assert_set_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    on && md == 3'b001 && hit |=> oc_ref);
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    on && md == 3'b011 && hit |=> oc_ref != $past(oc_ref));
  assert_force_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    on && md == 3'b101 |=> oc_ref);
  assert_pwm_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on && md == 3'b110 && !cnt_down |=> oc_ref == $past(cmp_q > cnt_val));
  assert_flag_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_flag);
  assert_flag_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !cmp_flag);
endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
  .cmp_q(cmp_q), .ctrl_q(ctrl_q), .oc_ref(oc_ref), .cmp_flag(cmp_flag)
);

// File: tb/tmr_oc_channel_test.sv
module tmr_oc_channel_test;
  localparam int W = 16;
  localparam int CMP = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, cfg_addr = 0, cnt_down = 0;
  logic [W-1:0] cfg_wdata = '0, cnt_val = '0;
  logic oc_ref, pin_out, cmp_flag;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_oc_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .oc_ref(oc_ref), .pin_out(pin_out), .cmp_flag(cmp_flag)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] ctl(int sel, int md, int pol, int en);
    return W'(sel) | W'(md << 2) | W'(pol << 5) | W'(en << 6);
  endfunction

  task automatic wr(logic a, logic [W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic step(int c, logic dn);
    cnt_val = W'(c); cnt_down = dn;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ref", oc_ref, 0);
    chk("R1 pin", pin_out, 0);
    chk("R1 flag", cmp_flag, 0);
  endtask

  task automatic t_cfg_timing;
    wr(1, W'(CMP));
    cnt_val = 0;
    wr(0, ctl(1, 5, 0, 1));
    chk("R2 old ctrl still governs ref", oc_ref, 0);
    step(0, 0);
    chk("R2 new ctrl applied", oc_ref, 1);
    chk("R10 pin follows ref", pin_out, 1);
  endtask

  task automatic t_forced;
    wr(0, ctl(1, 4, 0, 1));
    step(CMP, 0);
    chk("R7 force low", oc_ref, 0);
    chk("R11 flag while forced", cmp_flag, 1);
    step(3, 0);
    chk("R11 flag low off-match", cmp_flag, 0);
    wr(0, ctl(2, 4, 1, 1));
    step(5, 0);
    chk("R10 inverted pin", pin_out, 1);
    wr(0, ctl(2, 5, 1, 0));
    step(5, 0);
    chk("R7 force high", oc_ref, 1);
    chk("R10 disabled pin", pin_out, 0);
  endtask

  task automatic t_frozen;
    wr(0, ctl(1, 5, 0, 1));
    step(0, 0);
    wr(0, ctl(1, 0, 0, 1));
    for (int c = 0; c < 20; c++) begin
      step(c, c[0]);
      chk("R4 frozen holds", oc_ref, 1);
    end
  endtask

  task automatic t_set_clear;
    wr(0, ctl(3, 2, 0, 1));
    step(CMP - 1, 0);
    chk("R5 clear mode holds off-match", oc_ref, 1);
    step(CMP, 0);
    chk("R5 clear on match", oc_ref, 0);
    wr(0, ctl(3, 1, 0, 1));
    step(CMP + 1, 0);
    chk("R5 set mode holds off-match", oc_ref, 0);
    step(CMP, 0);
    chk("R5 set on match", oc_ref, 1);
  endtask

  task automatic t_toggle;
    logic exp;
    step(0, 0);
    wr(0, ctl(1, 3, 0, 1));
    exp = oc_ref;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 20; c++) begin
        step(c, 0);
        if (c == CMP) exp = ~exp;
        chk("R6 toggle on match", oc_ref, exp);
        chk("R11 flag in toggle", cmp_flag, c == CMP);
      end
  endtask

  task automatic t_pwm(bit inv);
    wr(0, ctl(1, inv ? 7 : 6, 0, 1));
    for (int c = 0; c < 20; c++) begin
      step(c, 0);
      chk(inv ? "R9 pwm B up" : "R8 pwm A up", oc_ref, (CMP > c) ^ inv);
      chk("R11 flag in pwm", cmp_flag, c == CMP);
    end
    for (int c = 19; c >= 0; c--) begin
      step(c, 1);
      chk(inv ? "R9 pwm B down" : "R8 pwm A down", oc_ref, (CMP >= c) ^ inv);
    end
  endtask

  task automatic t_sel_off;
    wr(0, ctl(1, 5, 0, 1));
    step(0, 0);
    wr(0, ctl(0, 5, 0, 1));
    step(0, 0);
    chk("R3 select off clears ref", oc_ref, 0);
    chk("R3 pin low", pin_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_cfg_timing();
    t_forced();
    t_frozen();
    t_set_clear();
    t_toggle();
    t_pwm(0);
    t_pwm(1);
    t_sel_off();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule